// File: doc/BRIEF.md
# Pad Boundary Scan Register

This block is the boundary scan data register for a group of general-purpose I/O pads. Every pad owns three scan cells: one for the pad input, one for the output level and one for the output enable. A TAP controller outside the block selects the chain and pulses capture, shift and update strobes. Those strobes load a snapshot of all pad signals, move the snapshot out on TDO while new test bits come in from TDI, and then copy the shifted bits into a bank of update latches.

The update latches hold preloaded test values. When the external test mode is selected, they drive each pad's output level and output enable in place of the core. When the internal test mode is selected, the core receives the pad-input latch in place of the real pad input. When neither mode is selected, the block does not disturb the pad paths, so a sample/preload pass is purely observational. The number of pads is a parameter. Each pad adds three cells to the chain, and the chain length is three times the pad count.

Top module: `padScanChain`

## Requirements
- R1: While `trstN` is low, every update latch and the TDO flop are cleared to 0, so under the external test mode `padOut` and `padOe` read all zero right after reset.
- R2: On a rising `tck` edge with `selChain` and `captureDr` high, the chain loads in parallel the pad-side signals of every pad: cell 3p gets `padIn[p]`, cell 3p+1 gets `padOut[p]` and cell 3p+2 gets `padOe[p]`.
- R3: On a rising `tck` edge with `selChain` and `shiftDr` high (and `captureDr` low), every cell takes the value of its neighbour one step farther from TDO, and `tdi` enters the far end (cell 3N-1).
- R4: `tdo` presents cell 0 and changes only on the falling edge of `tck`. A rising edge that shifts the chain leaves `tdo` unchanged until the next falling edge.
- R5: On a rising `tck` edge with `selChain` and `updateDr` high (capture and shift low), every cell's value is copied into its update latch. At all other times the latches hold.
- R6: With `selChain` low, the capture, shift and update strobes have no effect on either the chain or the latches.
- R7: With `modeExtest` high, `padOut[p]` equals update latch 3p+1 and `padOe[p]` equals update latch 3p+2. With it low, they follow `coreOut[p]` and `coreOe[p]`.
- R8: With `modeIntest` high, `coreIn[p]` equals update latch 3p. With it low, `coreIn[p]` follows `padIn[p]`.
- R9: The chain order is fixed: pad 0 lies nearest TDO, and within a pad the cells run input, output, output enable from TDO outward, so a capture followed by shifting presents pad 0's input first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling tck |
| selChain | input | 1 | Boundary chain selected by the current instruction |
| captureDr | input | 1 | Capture-DR strobe from the TAP |
| shiftDr | input | 1 | Shift-DR strobe from the TAP |
| updateDr | input | 1 | Update-DR strobe from the TAP |
| modeExtest | input | 1 | External test mode: latches drive the pads |
| modeIntest | input | 1 | Internal test mode: latch drives the core input |
| padIn | input | PADS | Level seen at each pad |
| coreOut | input | PADS | Output level requested by the core |
| coreOe | input | PADS | Output enable requested by the core |
| padOut | output | PADS | Output level sent to each pad |
| padOe | output | PADS | Output enable sent to each pad |
| coreIn | output | PADS | Input level delivered to the core |

## Verification
The bench captures distinct patterns and reads every bit back on TDO. A chain with a swapped cell order or a reversed shift direction would return the bits in the wrong positions. It samples TDO right after a shifting rising edge, so a design that drives TDO from the rising edge would show the next bit one half-cycle early. It captures while the external mode is active, which exposes a design that samples the core's request instead of the real pad-side value. It also pulses every strobe with the chain deselected, then checks through the pad outputs and a fresh shift-out that nothing moved. Finally, it confirms after reset that no pad is driven by a stale latch.

// File: rtl/padScanPkg.sv
package padScanPkg;
  localparam int CELLS_PER_PAD = 3;
  localparam int CELL_IN  = 0;
  localparam int CELL_OUT = 1;
  localparam int CELL_OE  = 2;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic extest;
    logic intest;
  } scanCtl_t;
endpackage

// File: rtl/scanCtrl.sv
module scanCtrl
  import padScanPkg::*;
(
  input  logic     selChain,
  input  logic     captureDr,
  input  logic     shiftDr,
  input  logic     updateDr,
  input  logic     modeExtest,
  input  logic     modeIntest,
  output scanCtl_t ctl
);
  // Strobes act only with the chain selected; capture wins over shift, shift over update.
  always_comb begin
    ctl.capture = selChain & captureDr;
    ctl.shift   = selChain & shiftDr & ~captureDr;
    ctl.update  = selChain & updateDr & ~captureDr & ~shiftDr;
    ctl.extest  = modeExtest;
    ctl.intest  = modeIntest;
  end
endmodule

// File: rtl/scanDatapath.sv
module scanDatapath
  import padScanPkg::*;
#(
  parameter int PADS = 8,
  localparam int LEN = PADS * CELLS_PER_PAD
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  input  scanCtl_t        ctl,
  input  logic [PADS-1:0] padIn,
  input  logic [PADS-1:0] coreOut,
  input  logic [PADS-1:0] coreOe,
  output logic [PADS-1:0] padOut,
  output logic [PADS-1:0] padOe,
  output logic [PADS-1:0] coreIn,
  output logic            tdo,
  output logic [LEN-1:0]  shiftVec,
  output logic [LEN-1:0]  updVec
);
  logic [LEN-1:0] capVec;
  logic [LEN-1:0] shiftQ;
  logic [LEN-1:0] updQ;
  logic           tdoQ;

  for (genvar p = 0; p < PADS; p++) begin : gPad
    localparam int BASE = p * CELLS_PER_PAD;
    assign padOut[p] = ctl.extest ? updQ[BASE + CELL_OUT] : coreOut[p];
    assign padOe[p]  = ctl.extest ? updQ[BASE + CELL_OE]  : coreOe[p];
    assign coreIn[p] = ctl.intest ? updQ[BASE + CELL_IN]  : padIn[p];
    assign capVec[BASE + CELL_IN]  = padIn[p];
    assign capVec[BASE + CELL_OUT] = padOut[p];
    assign capVec[BASE + CELL_OE]  = padOe[p];
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftQ <= '0;
    end else if (ctl.capture) begin
      shiftQ <= capVec;
    end else if (ctl.shift) begin
      shiftQ <= {tdi, shiftQ[LEN-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      updQ <= '0;
    end else if (ctl.update) begin
      updQ <= shiftQ;
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdoQ <= 1'b0;
    end else begin
      tdoQ <= shiftQ[0];
    end
  end

  assign tdo      = tdoQ;
  assign shiftVec = shiftQ;
  assign updVec   = updQ;
endmodule

// File: rtl/padScanChain.sv
module padScanChain
  import padScanPkg::*;
#(
  parameter int PADS = 8
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            tdi,
  output logic            tdo,
  input  logic            selChain,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  input  logic            modeExtest,
  input  logic            modeIntest,
  input  logic [PADS-1:0] padIn,
  input  logic [PADS-1:0] coreOut,
  input  logic [PADS-1:0] coreOe,
  output logic [PADS-1:0] padOut,
  output logic [PADS-1:0] padOe,
  output logic [PADS-1:0] coreIn
);
  localparam int LEN = PADS * CELLS_PER_PAD;

  scanCtl_t       ctl;
  logic [LEN-1:0] shiftVec;
  logic [LEN-1:0] updVec;

  scanCtrl uCtrl (
    .selChain   (selChain),
    .captureDr  (captureDr),
    .shiftDr    (shiftDr),
    .updateDr   (updateDr),
    .modeExtest (modeExtest),
    .modeIntest (modeIntest),
    .ctl        (ctl)
  );

  scanDatapath #(.PADS(PADS)) uData (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .ctl      (ctl),
    .padIn    (padIn),
    .coreOut  (coreOut),
    .coreOe   (coreOe),
    .padOut   (padOut),
    .padOe    (padOe),
    .coreIn   (coreIn),
    .tdo      (tdo),
    .shiftVec (shiftVec),
    .updVec   (updVec)
  );
endmodule

// File: rtl/padScanChk.sv
module padScanChk #(
  parameter int PADS = 8,
  localparam int LEN = PADS * 3
) (
  input logic            tck,
  input logic            trstN,
  input logic            tdi,
  input logic            selChain,
  input logic            captureDr,
  input logic            shiftDr,
  input logic            updateDr,
  input logic            modeExtest,
  input logic            modeIntest,
  input logic [PADS-1:0] padIn,
  input logic [PADS-1:0] padOut,
  input logic [PADS-1:0] padOe,
  input logic [PADS-1:0] coreIn,
  input logic [LEN-1:0]  shiftVec,
  input logic [LEN-1:0]  updVec
);
  logic [LEN-1:0] seen;
  logic [PADS-1:0] latOut, latOe, latIn;
  always_comb begin
    for (int p = 0; p < PADS; p++) begin
      seen[3*p]     = padIn[p];
      seen[3*p + 1] = padOut[p];
      seen[3*p + 2] = padOe[p];
      latIn[p]      = updVec[3*p];
      latOut[p]     = updVec[3*p + 1];
      latOe[p]      = updVec[3*p + 2];
    end
  end

  always @(posedge tck) begin
    if (trstN === 1'b0) begin
      AST_RESET_CLEAR: assert (updVec == '0); // R1
    end
  end

  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!trstN)
    (selChain && captureDr) |=> shiftVec == $past(seen)); // R2

  AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (!trstN)
    (selChain && shiftDr && !captureDr) |=> shiftVec == {$past(tdi), $past(shiftVec[LEN-1:1])}); // R3

  AST_UPDATE_COPY: assert property (@(posedge tck) disable iff (!trstN)
    (selChain && updateDr && !captureDr && !shiftDr) |=> updVec == $past(shiftVec)); // R5

  AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    !(selChain && updateDr) |=> $stable(updVec)); // R6

  AST_IDLE_CHAIN: assert property (@(posedge tck) disable iff (!trstN)
    !selChain |=> $stable(shiftVec)); // R6

  AST_EXTEST_DRIVE: assert property (@(posedge tck) disable iff (!trstN)
    modeExtest |-> (padOut == latOut && padOe == latOe)); // R7

  AST_INTEST_DRIVE: assert property (@(posedge tck) disable iff (!trstN)
    modeIntest |-> coreIn == latIn); // R8
endmodule

bind padScanChain padScanChk #(.PADS(PADS)) uChk (
  .tck        (tck),
  .trstN      (trstN),
  .tdi        (tdi),
  .selChain   (selChain),
  .captureDr  (captureDr),
  .shiftDr    (shiftDr),
  .updateDr   (updateDr),
  .modeExtest (modeExtest),
  .modeIntest (modeIntest),
  .padIn      (padIn),
  .padOut     (padOut),
  .padOe      (padOe),
  .coreIn     (coreIn),
  .shiftVec   (shiftVec),
  .updVec     (updVec)
);

// File: tb/sim_padScanChain.sv
`timescale 1ns/1ps
module sim_padScanChain;
  localparam int N = 4;
  localparam int L = 3 * N;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tdi = 1'b0;
  logic tdo;
  logic selChain = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic modeExtest = 1'b0, modeIntest = 1'b0;
  logic [N-1:0] padIn = '0, coreOut = '0, coreOe = '0;
  logic [N-1:0] padOut, padOe, coreIn;

  int total = 0;
  int bad = 0;

  always #2.5 tck = ~tck;

  padScanChain #(.PADS(N)) u0 (
    .tck(tck), .trstN(trstN), .tdi(tdi), .tdo(tdo),
    .selChain(selChain), .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .modeExtest(modeExtest), .modeIntest(modeIntest),
    .padIn(padIn), .coreOut(coreOut), .coreOe(coreOe),
    .padOut(padOut), .padOe(padOe), .coreIn(coreIn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // latch bits split per pad: input cell 3p, output 3p+1, enable 3p+2
  function automatic logic [N-1:0] pick(input logic [L-1:0] v, input int off);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = v[3*p + off];
    return r;
  endfunction

  function automatic logic [L-1:0] weave(input logic [N-1:0] i, input logic [N-1:0] o,
                                         input logic [N-1:0] e);
    logic [L-1:0] r;
    for (int p = 0; p < N; p++) begin
      r[3*p] = i[p]; r[3*p+1] = o[p]; r[3*p+2] = e[p];
    end
    return r;
  endfunction

  task automatic pulseCapture();
    captureDr = 1'b1;
    @(posedge tck); #1;
    captureDr = 1'b0;
  endtask

  task automatic pulseUpdate();
    updateDr = 1'b1;
    @(posedge tck); #1;
    updateDr = 1'b0;
  endtask

  // Shifts L bits in; returns what appeared on tdo, checking tdo holds across rising edges.
  task automatic shiftAll(input logic [L-1:0] inV, output logic [L-1:0] outV);
    shiftDr = 1'b1;
    for (int k = 0; k < L; k++) begin
      tdi = inV[k];
      @(negedge tck); #1;
      outV[k] = tdo;
      @(posedge tck); #1;
      if (k == 0 || k == L - 1) check("R4 tdo held after rising edge", tdo, outV[k]);
    end
    shiftDr = 1'b0;
  endtask

  task automatic testReset();
    trstN = 1'b0;
    repeat (3) @(posedge tck);
    #1;
    modeExtest = 1'b1; modeIntest = 1'b1;
    #1;
    check("R1 padOut after reset", padOut, '0);
    check("R1 padOe after reset", padOe, '0);
    check("R1 coreIn after reset", coreIn, '0);
    check("R1 tdo after reset", tdo, 1'b0);
    modeExtest = 1'b0; modeIntest = 1'b0;
    @(posedge tck); #1;
    trstN = 1'b1;
    @(posedge tck); #1;
  endtask

  task automatic testSamplePreload();
    logic [L-1:0] got;
    logic [L-1:0] newBits = 12'b1011_0110_0101;
    padIn = 4'b1001; coreOut = 4'b0110; coreOe = 4'b1100;
    #1;
    check("R9 padOut passthrough", padOut, coreOut);
    check("R9 padOe passthrough", padOe, coreOe);
    check("R9 coreIn passthrough", coreIn, padIn);
    selChain = 1'b1;
    pulseCapture();
    shiftAll(newBits, got);
    check("R2 R3 R9 captured bits on tdo", got, weave(4'b1001, 4'b0110, 4'b1100));
    check("R9 first bit is pad0 input", got[0], 1'b1);
    check("R5 no change before update", padOut, coreOut);
    pulseUpdate();
    modeExtest = 1'b1; #1;
    check("R7 padOut from latches", padOut, pick(newBits, 1));
    check("R7 padOe from latches", padOe, pick(newBits, 2));
    modeExtest = 1'b0; modeIntest = 1'b1; #1;
    check("R8 coreIn from latch", coreIn, pick(newBits, 0));
    check("R7 padOut back to core", padOut, coreOut);
    modeIntest = 1'b0; #1;
    check("R8 coreIn back to pad", coreIn, padIn);
  endtask

  task automatic testCaptureExtest();
    logic [L-1:0] got;
    logic [L-1:0] latched = 12'b1011_0110_0101;
    // latches still hold the previous preload; capture must see the driven pad side
    modeExtest = 1'b1;
    padIn = 4'b0011;
    pulseCapture();
    shiftAll('0, got);
    check("R2 capture pad-side under extest", got,
          weave(4'b0011, pick(latched, 1), pick(latched, 2)));
    check("R5 latches held through shift", padOut, pick(latched, 1));
    modeExtest = 1'b0;
  endtask

  task automatic testDeselected();
    logic [L-1:0] got;
    logic [L-1:0] marker = 12'b1110_0001_1010;
    logic [L-1:0] prevLatch = 12'b1011_0110_0101;
    // preload chain with a marker, leave latches holding prevLatch
    shiftAll(marker, got);
    check("R3 zeros shifted in earlier", got, '0);
    selChain = 1'b0;
    padIn = 4'b1111; coreOut = 4'b1111; coreOe = 4'b1111;
    captureDr = 1'b1; @(posedge tck); #1; captureDr = 1'b0;
    shiftDr = 1'b1; tdi = 1'b0; repeat (3) @(posedge tck); #1; shiftDr = 1'b0;
    updateDr = 1'b1; @(posedge tck); #1; updateDr = 1'b0;
    modeExtest = 1'b1; #1;
    check("R6 latches unchanged while deselected", padOut, pick(prevLatch, 1));
    check("R6 enables unchanged while deselected", padOe, pick(prevLatch, 2));
    modeExtest = 1'b0;
    selChain = 1'b1;
    shiftAll('0, got);
    check("R6 chain unchanged while deselected", got, marker);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testSamplePreload();
    testCaptureExtest();
    testDeselected();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule